// File: doc/BRIEF.md
# Defect-Aware Codeword Segment Allocator

This block scans a per-cell defect bitmap of a memory array and carves the array into variable-length segments, each sized to hold one error-correcting codeword for a fixed-size user block. A group of codes is supplied as a table. Each code has a correction strength and a redundancy in cells. For each segment the block picks the cheapest code that can absorb the defective cells inside the segment plus a fixed margin kept in reserve for transient errors. It emits one record per segment, holding the head address and the code index.

The segment length and the code choice depend on each other, so the block finds them together. It opens a window of user-length cells at an aligned start address and counts the defects in it. It then picks a code, grows the window by that code's redundancy, and counts the new cells. It repeats until the chosen code covers the count. When no code in the group can cover the window, the start jumps just past the first defective cell and a fresh attempt begins. The defect map is read through a synchronous one-bit port with one cycle of latency. Records leave on a valid/ready handshake, and the whole scan waits while a record is refused.

Top module: `seg_alloc`

## Requirements
- R1: After reset, and until start_i is seen, rec_valid_o, done_o and dm_rd_o are all 0.
- R2: Every segment head is a multiple of 2^align_log2_i. Each attempt starts at the start pointer rounded up to the next such multiple, and the first attempt starts from cell 0. rec_slot_o equals rec_head_o shifted right by align_log2_i.
- R3: The reported code is the one with the fewest redundant cells among all codes whose strength is at least the window's defect count plus margin_i. On equal redundancy the lowest index wins. Code k has strength code_t_i[k*T_W +: T_W] and redundancy code_r_i[k*R_W +: R_W].
- R4: An accepted segment spans user_len_i plus the chosen code's redundancy, in cells from its head. The defect count in that span plus margin_i does not exceed the chosen strength.
- R5: When the defect count plus margin_i exceeds the largest strength in the table, the start pointer moves to one past the first defective cell at or after the current start. The next attempt is rounded up from there.
- R6: After a record is taken, the next attempt begins at the end of the accepted segment, rounded up per R2.
- R7: The scan ends with done_o held at 1 and no further record when one of three things happens: an opened window would pass cell 2^ADDR_W, a grown window would pass it, or a skip finds no defective cell before the end of the array.
- R8: While rec_valid_o is 1 and rec_ready_i is 0, rec_valid_o stays 1 and rec_head_o, rec_slot_o and rec_code_o stay unchanged.
- R9: A start_i pulse after done_o restarts a complete scan from cell 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scan (idle or done) |
| user_len_i | input | ADDR_W+1 | User block length in cells |
| margin_i | input | T_W | Transient-error margin in correctable errors |
| align_log2_i | input | $clog2(ADDR_W+1) | Log2 of the head alignment |
| code_t_i | input | NUM_CODES*T_W | Correction strength per code |
| code_r_i | input | NUM_CODES*R_W | Redundant cells per code |
| dm_rd_o | output | 1 | Defect map read enable |
| dm_addr_o | output | ADDR_W | Defect map read address |
| dm_bit_i | input | 1 | Defect bit, one cycle after the address |
| rec_valid_o | output | 1 | Segment record valid |
| rec_ready_i | input | 1 | Segment record accepted |
| rec_head_o | output | ADDR_W | Segment head cell address |
| rec_slot_o | output | ADDR_W | Head address divided by the alignment |
| rec_code_o | output | $clog2(NUM_CODES) | Selected code index |
| done_o | output | 1 | Scan finished |

## Verification
The assertions check on every cycle that a presented record is aligned, lies inside the array and is covered by its code's strength. They also check that the code picker's choice meets the demand, that a refused record holds still, and that nothing is read or offered once the scan is done. Only the bench scenarios can show that the sequence of heads and codes is right: which code is cheapest, how far a skip moves the start, and where the scan stops. To do that, the bench compares every record against an independent walk of the same bitmap, using clean, sparse, clustered and overloaded maps, two code tables, and both random and constant handshake patterns.

// File: rtl/seg_alloc_pkg.sv
package seg_alloc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ALIGN, ST_CNT, ST_CHECK, ST_FIND, ST_EMIT, ST_DONE
  } seg_state_e;

  typedef enum logic [1:0] {
    RD_NONE, RD_COUNT, RD_FIND
  } rd_cmd_e;
endpackage

// File: rtl/seg_code_pick.sv
module seg_code_pick #(
  parameter int NUM_CODES = 8,
  parameter int T_W       = 6,
  parameter int R_W       = 8,
  parameter int NEED_W    = 12,
  localparam int IDX_W    = $clog2(NUM_CODES)
) (
  input  logic [NUM_CODES*T_W-1:0] code_t_i,
  input  logic [NUM_CODES*R_W-1:0] code_r_i,
  input  logic [NEED_W-1:0]        need_i,
  output logic                     fit_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic [T_W-1:0]           t_o,
  output logic [R_W-1:0]           r_o,
  output logic [T_W-1:0]           tmax_o
);
  always_comb begin
    logic [T_W-1:0] tk;
    logic [R_W-1:0] rk;
    fit_o  = 1'b0;
    idx_o  = '0;
    t_o    = '0;
    r_o    = '0;
    tmax_o = '0;
    for (int k = 0; k < NUM_CODES; k++) begin
      tk = code_t_i[k*T_W +: T_W];
      rk = code_r_i[k*R_W +: R_W];
      if (tk > tmax_o) tmax_o = tk;
      // strict < keeps the lowest index on equal redundancy
      if (NEED_W'(tk) >= need_i && (!fit_o || rk < r_o)) begin
        fit_o = 1'b1;
        idx_o = IDX_W'(k);
        t_o   = tk;
        r_o   = rk;
      end
    end
  end
endmodule

// File: rtl/seg_map_reader.sv
module seg_map_reader
  import seg_alloc_pkg::*;
#(
  parameter int PTR_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rd_cmd_e          cmd_i,
  input  logic [PTR_W-1:0] from_i,
  input  logic [PTR_W-1:0] to_i,
  output logic             dm_rd_o,
  output logic [PTR_W-2:0] dm_addr_o,
  input  logic             dm_bit_i,
  output logic             fin_o,
  output logic [PTR_W-1:0] hits_o,
  output logic             found_o,
  output logic [PTR_W-1:0] found_addr_o
);
  logic             active_q, find_q, pend_q;
  logic [PTR_W-1:0] ptr_q, bound_q, pend_addr_q;
  logic             hit_now, stop_find, issue;

  assign hit_now   = pend_q & dm_bit_i;
  assign stop_find = find_q & hit_now;
  assign issue     = active_q & (ptr_q < bound_q) & ~stop_find;
  assign dm_rd_o   = issue;
  assign dm_addr_o = ptr_q[PTR_W-2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q     <= 1'b0;
      find_q       <= 1'b0;
      pend_q       <= 1'b0;
      ptr_q        <= '0;
      bound_q      <= '0;
      pend_addr_q  <= '0;
      hits_o       <= '0;
      found_o      <= 1'b0;
      found_addr_o <= '0;
      fin_o        <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (!active_q) begin
        if (cmd_i != RD_NONE) begin
          active_q <= 1'b1;
          find_q   <= (cmd_i == RD_FIND);
          ptr_q    <= from_i;
          bound_q  <= to_i;
          hits_o   <= '0;
          found_o  <= 1'b0;
          pend_q   <= 1'b0;
        end
      end else begin
        pend_q      <= issue;
        pend_addr_q <= ptr_q;
        if (issue) ptr_q <= ptr_q + 1'b1;
        if (hit_now) hits_o <= hits_o + 1'b1;
        if (stop_find) begin
          found_o      <= 1'b1;
          found_addr_o <= pend_addr_q;
          active_q     <= 1'b0;
          fin_o        <= 1'b1;
        end else if (!issue && !pend_q) begin
          active_q <= 1'b0;
          fin_o    <= 1'b1;
        end
      end
    end
  end

  assert_read_in_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_rd_o |-> (ptr_q < bound_q));
endmodule

// File: rtl/seg_alloc.sv
module seg_alloc
  import seg_alloc_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_CODES = 8,
  parameter int T_W       = 6,
  parameter int R_W       = 8,
  localparam int PTR_W    = ADDR_W + 1,
  localparam int NEED_W   = PTR_W + 1,
  localparam int W2       = PTR_W + 2,
  localparam int ALIGN_W  = $clog2(ADDR_W + 1),
  localparam int IDX_W    = $clog2(NUM_CODES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [PTR_W-1:0]         user_len_i,
  input  logic [T_W-1:0]           margin_i,
  input  logic [ALIGN_W-1:0]       align_log2_i,
  input  logic [NUM_CODES*T_W-1:0] code_t_i,
  input  logic [NUM_CODES*R_W-1:0] code_r_i,
  output logic                     dm_rd_o,
  output logic [ADDR_W-1:0]        dm_addr_o,
  input  logic                     dm_bit_i,
  output logic                     rec_valid_o,
  input  logic                     rec_ready_i,
  output logic [ADDR_W-1:0]        rec_head_o,
  output logic [ADDR_W-1:0]        rec_slot_o,
  output logic [IDX_W-1:0]         rec_code_o,
  output logic                     done_o
);
  localparam logic [W2-1:0] CELLS = W2'(1) << ADDR_W;

  seg_state_e       state_q;
  logic [PTR_W-1:0] seg_s_q, seg_e_q, dcnt_q;
  logic             has_code_q;
  logic [T_W-1:0]   cur_t_q;
  logic [IDX_W-1:0] cur_idx_q;

  // alignment and window arithmetic
  logic [W2-1:0]     al_mask, s_up, open_end, grow_end;
  logic              open_fail, grow_fail;
  logic [NEED_W-1:0] need;
  logic              covered, too_many;

  // picker
  logic             pick_fit;
  logic [IDX_W-1:0] pick_idx;
  logic [T_W-1:0]   pick_t, pick_tmax;
  logic [R_W-1:0]   pick_r;

  // reader
  rd_cmd_e          rd_cmd;
  logic [PTR_W-1:0] rd_from, rd_to, rd_hits, rd_found_addr;
  logic             rd_fin, rd_found;

  assign al_mask   = (W2'(1) << align_log2_i) - W2'(1);
  assign s_up      = (W2'(seg_s_q) + al_mask) & ~al_mask;
  assign open_end  = s_up + W2'(user_len_i);
  assign open_fail = open_end > CELLS;
  assign grow_end  = W2'(seg_s_q) + W2'(user_len_i) + W2'(pick_r);
  assign grow_fail = grow_end > CELLS;
  assign need      = NEED_W'(dcnt_q) + NEED_W'(margin_i);
  assign covered   = has_code_q && (NEED_W'(cur_t_q) >= need);
  assign too_many  = need > NEED_W'(pick_tmax);

  seg_code_pick #(
    .NUM_CODES(NUM_CODES), .T_W(T_W), .R_W(R_W), .NEED_W(NEED_W)
  ) u_pick (
    .code_t_i(code_t_i), .code_r_i(code_r_i), .need_i(need),
    .fit_o(pick_fit), .idx_o(pick_idx), .t_o(pick_t), .r_o(pick_r),
    .tmax_o(pick_tmax)
  );

  always_comb begin
    rd_cmd  = RD_NONE;
    rd_from = '0;
    rd_to   = '0;
    unique case (state_q)
      ST_ALIGN: if (!open_fail) begin
        rd_cmd  = RD_COUNT;
        rd_from = PTR_W'(s_up);
        rd_to   = PTR_W'(open_end);
      end
      ST_CHECK: if (!covered) begin
        if (too_many) begin
          rd_cmd  = RD_FIND;
          rd_from = seg_s_q;
          rd_to   = PTR_W'(CELLS);
        end else if (!grow_fail) begin
          rd_cmd  = RD_COUNT;
          rd_from = seg_e_q;
          rd_to   = PTR_W'(grow_end);
        end
      end
      default: ;
    endcase
  end

  seg_map_reader #(.PTR_W(PTR_W)) u_reader (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(rd_cmd), .from_i(rd_from),
    .to_i(rd_to), .dm_rd_o(dm_rd_o), .dm_addr_o(dm_addr_o),
    .dm_bit_i(dm_bit_i), .fin_o(rd_fin), .hits_o(rd_hits),
    .found_o(rd_found), .found_addr_o(rd_found_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      seg_s_q    <= '0;
      seg_e_q    <= '0;
      dcnt_q     <= '0;
      has_code_q <= 1'b0;
      cur_t_q    <= '0;
      cur_idx_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          seg_s_q <= '0;
          state_q <= ST_ALIGN;
        end
        ST_ALIGN: begin
          if (open_fail) state_q <= ST_DONE;
          else begin
            seg_s_q    <= PTR_W'(s_up);
            seg_e_q    <= PTR_W'(open_end);
            dcnt_q     <= '0;
            has_code_q <= 1'b0;
            state_q    <= ST_CNT;
          end
        end
        ST_CNT: if (rd_fin) begin
          dcnt_q  <= dcnt_q + rd_hits;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (covered)        state_q <= ST_EMIT;
          else if (too_many)  state_q <= ST_FIND;
          else if (grow_fail) state_q <= ST_DONE;
          else begin
            cur_idx_q  <= pick_idx;
            cur_t_q    <= pick_t;
            has_code_q <= 1'b1;
            seg_e_q    <= PTR_W'(grow_end);
            state_q    <= ST_CNT;
          end
        end
        ST_FIND: if (rd_fin) begin
          if (rd_found) begin
            seg_s_q <= rd_found_addr + 1'b1;
            state_q <= ST_ALIGN;
          end else state_q <= ST_DONE;
        end
        ST_EMIT: if (rec_ready_i) begin
          seg_s_q <= seg_e_q;
          state_q <= ST_ALIGN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rec_valid_o = (state_q == ST_EMIT);
  assign done_o      = (state_q == ST_DONE);
  assign rec_head_o  = seg_s_q[ADDR_W-1:0];
  assign rec_slot_o  = rec_head_o >> align_log2_i;
  assign rec_code_o  = cur_idx_q;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!rec_valid_o && !done_o && !dm_rd_o));
  assert_head_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (!seg_s_q[ADDR_W] && ((W2'(seg_s_q) & al_mask) == '0)));
  assert_pick_meets_need_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK && !covered && !too_many) |-> (pick_fit && NEED_W'(pick_t) >= need));
  assert_code_covers_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (has_code_q && NEED_W'(cur_t_q) >= need && seg_e_q <= PTR_W'(CELLS)));
  assert_done_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rec_valid_o && !dm_rd_o));
  assert_rec_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_head_o) && $stable(rec_code_o)));
  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (!done_o && seg_s_q == '0));
endmodule

// File: tb/seg_alloc_bench.sv
`timescale 1ns/1ps
module seg_alloc_bench;
  localparam int ADDR_W = 10;
  localparam int N      = 1 << ADDR_W;
  localparam int NC     = 8;
  localparam int T_W    = 6;
  localparam int R_W    = 8;
  localparam int AW     = $clog2(ADDR_W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W:0] ulen = '0;
  logic [T_W-1:0] margin = '0;
  logic [AW-1:0] al = '0;
  logic [NC*T_W-1:0] code_t = '0;
  logic [NC*R_W-1:0] code_r = '0;
  logic dm_rd, dm_bit = 1'b0;
  logic [ADDR_W-1:0] dm_addr;
  logic rec_valid, rdy = 1'b1;
  logic [ADDR_W-1:0] rec_head, rec_slot;
  logic [2:0] rec_code;
  logic done;

  bit map_q [N];
  int tab_t [NC];
  int tab_r [NC];
  int exp_h [$];
  int exp_c [$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit stall_mode = 1'b0;
  string cur_req = "R6";

  always #2.5 clk = ~clk;

  seg_alloc u_seg_alloc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .user_len_i(ulen),
    .margin_i(margin), .align_log2_i(al), .code_t_i(code_t), .code_r_i(code_r),
    .dm_rd_o(dm_rd), .dm_addr_o(dm_addr), .dm_bit_i(dm_bit),
    .rec_valid_o(rec_valid), .rec_ready_i(rdy), .rec_head_o(rec_head),
    .rec_slot_o(rec_slot), .rec_code_o(rec_code), .done_o(done)
  );

  always @(posedge clk) dm_bit <= map_q[dm_addr];
  always @(posedge clk) #1 rdy <= stall_mode ? ($urandom_range(0, 3) == 0) : 1'b1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  logic prev_v = 1'b0, prev_r = 1'b0;
  logic [ADDR_W-1:0] prev_h = '0;
  logic [2:0] prev_c = '0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
    end
    if (prev_v && !prev_r && rst_n) begin
      check(rec_valid && rec_head == prev_h && rec_code == prev_c, "R8",
            "record held under stall (head)", int'(rec_head), int'(prev_h));
    end
    if (rec_valid && rdy) begin
      if (exp_h.size() == 0) begin
        check(1'b0, "R7", "unexpected record head", int'(rec_head), -1);
      end else begin
        int eh, ec;
        eh = exp_h.pop_front();
        ec = exp_c.pop_front();
        check(int'(rec_head) == eh, cur_req, "segment head", int'(rec_head), eh);
        check(int'(rec_code) == ec, "R3", "code index", int'(rec_code), ec);
        check(int'(rec_slot) == (int'(rec_head) >> al) && (int'(rec_head) % (1 << al)) == 0,
              "R2", "aligned slot", int'(rec_slot), int'(rec_head) >> al);
      end
    end
    prev_v = rec_valid; prev_r = rdy; prev_h = rec_head; prev_c = rec_code;
  end

  task automatic set_table(input int t[NC], input int r[NC]);
    for (int k = 0; k < NC; k++) begin
      tab_t[k] = t[k];
      tab_r[k] = r[k];
      code_t[k*T_W +: T_W] = T_W'(t[k]);
      code_r[k*R_W +: R_W] = R_W'(r[k]);
    end
  endtask

  task automatic fill_map(int pct, int lo, int hi);
    for (int i = 0; i < N; i++)
      map_q[i] = (pct > 0 && $urandom_range(0, 99) < pct) || (i >= lo && i < hi);
  endtask

  // independent walk of the requirements
  task automatic model_run();
    int s, e, d, need, tmax, a, t, idx, r, f;
    bit has, stop;
    a = 1 << al;
    tmax = 0;
    for (int k = 0; k < NC; k++) if (tab_t[k] > tmax) tmax = tab_t[k];
    s = 0; stop = 0;
    while (!stop) begin
      s = ((s + a - 1) / a) * a;
      if (s + int'(ulen) > N) break;
      e = s + int'(ulen); has = 0; t = 0; idx = 0;
      forever begin
        d = 0;
        for (int i = s; i < e; i++) d += int'(map_q[i]);
        need = d + int'(margin);
        if (has && t >= need) begin
          exp_h.push_back(s); exp_c.push_back(idx);
          s = e;
          break;
        end
        if (need > tmax) begin
          f = -1;
          for (int i = s; i < N; i++) if (map_q[i]) begin f = i; break; end
          if (f < 0) stop = 1; else s = f + 1;
          break;
        end
        r = -1;
        for (int k = 0; k < NC; k++)
          if (tab_t[k] >= need && (r < 0 || tab_r[k] < r)) begin r = tab_r[k]; idx = k; t = tab_t[k]; end
        if (s + int'(ulen) + r > N) begin stop = 1; break; end
        e = s + int'(ulen) + r; has = 1;
      end
    end
  endtask

  task automatic run_scan(string req, int n_exp_min);
    int waited;
    exp_h.delete(); exp_c.delete();
    model_run();
    cur_req = req;
    check(exp_h.size() >= n_exp_min, req, "scenario yields records", exp_h.size(), n_exp_min);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(!done, "R9", "restart clears done", int'(done), 0);
    waited = 0;
    while (!done && waited < 40000) begin @(negedge clk); waited++; end
    check(done && !rec_valid, "R7", "scan finished", int'(done), 1);
    check(exp_h.size() == 0, "R7", "records left undelivered", exp_h.size(), 0);
    repeat (3) @(negedge clk);
    check(done && !rec_valid && !dm_rd, "R7", "done held quiet", int'(done), 1);
  endtask

  initial begin
    set_table('{1, 2, 3, 4, 6, 8, 10, 12}, '{11, 22, 33, 44, 66, 88, 110, 132});
    repeat (3) @(negedge clk);
    check(!rec_valid && !done && !dm_rd, "R1", "outputs in reset", int'(rec_valid | done | dm_rd), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!rec_valid && !done && !dm_rd, "R1", "idle before start", int'(rec_valid | done | dm_rd), 0);

    // clean map, 64-cell alignment
    fill_map(0, 0, 0); ulen = 100; margin = 0; al = 6;
    run_scan("R6", 8);
    // sparse defects, margin 1
    fill_map(3, 0, 0); ulen = 100; margin = 1; al = 4;
    run_scan("R4", 3);
    // dense cluster forcing skips, no alignment
    fill_map(2, 300, 420); ulen = 60; margin = 2; al = 0;
    run_scan("R5", 3);
    // non-monotone table with ties, random handshake
    set_table('{2, 4, 4, 6, 8, 8, 12, 12}, '{30, 50, 45, 60, 70, 70, 100, 90});
    fill_map(5, 0, 0); ulen = 128; margin = 3; al = 5; stall_mode = 1'b1;
    run_scan("R3", 2);
    stall_mode = 1'b0;
    // margin beyond every strength: nothing emitted
    fill_map(0, 0, 0); margin = 13; ulen = 50; al = 0;
    run_scan("R5", 0);
    fill_map(1, 0, 0);
    run_scan("R5", 0);
    // end-of-array boundaries
    set_table('{1, 2, 3, 4, 6, 8, 10, 12}, '{11, 22, 33, 44, 66, 88, 110, 132});
    fill_map(0, 0, 0); margin = 0; ulen = 1000; al = 0;
    run_scan("R7", 1);
    ulen = 1020;
    run_scan("R7", 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule